// File: doc/BRIEF.md
# Paired-Core Lookup RAM with Shared Second Port

This block holds the lookup RAMs of two processor cores that form a pair (their IDs differ only in the lowest bit). Each core owns a dual-port RAM. The first port is the core's own read/write port. The second port has two possible users. The core's streamer uses it for reads, and the partner core uses it for writes. Whenever a core writes through its first port, the same write is offered to the partner's RAM. The partner takes that write only if its own sharing bit is set.

The second port has a fixed priority: a neighbour write always wins over a streamer read. In a cycle where both want the port, the streamer's address is dropped. The streamer then gets the word being written, and a conflict flag marks the cycle so that a glitched fetch can be detected. While a streamer is in a mode that fetches from hub memory instead of the lookup RAM, its requests are ignored and no conflict can arise.

Top module: `lut_share_pair`

## Requirements
- R1: After reset, every sharing bit is 0, and `loc_rdata`, `strm_valid` and `strm_conflict` are all 0.
- R2: A port-1 write (`loc_en`=1, `loc_we`=1) stores `loc_wdata` at `loc_addr`. A later port-1 read (`loc_en`=1, `loc_we`=0) puts that word on `loc_rdata` in the cycle after the read is presented.
- R3: When core j has sharing enabled, a port-1 write by core j^1 is also stored in core j's RAM at the same address.
- R4: When core j has sharing disabled, port-1 writes by core j^1 leave core j's RAM unchanged.
- R5: A pulse on `share_wr[j]` loads `share_val[j]` into core j's sharing bit, and the new value governs neighbour writes from the next cycle on. A neighbour write in the same cycle as the update is judged by the old value.
- R6: With `strm_lut_mode[j]`=1 and `strm_rd[j]`=1, and no accepted neighbour write, the next cycle shows the word at `strm_addr[j]` on `strm_rdata[j]`, with `strm_valid[j]`=1 and `strm_conflict[j]`=0.
- R7: If an accepted neighbour write and a lookup-mode streamer read fall in the same cycle, the write completes. The next cycle shows `strm_valid`=1, `strm_conflict`=1, and `strm_rdata` equal to the written word, whatever the requested address was.
- R8: With `strm_lut_mode[j]`=0, streamer reads are ignored: `strm_valid[j]` and `strm_conflict[j]` stay 0 in the next cycle, and neighbour writes still land.
- R9: If core j's own port-1 write and an accepted neighbour write hit the same address in the same cycle, core j's own data is the data kept.
- R10: `strm_conflict` is never 1 unless `strm_valid` is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_en | input | 2 | Port-1 access strobe, one per core |
| loc_we | input | 2 | Port-1 write select, one per core |
| loc_addr | input | 2x9 | Port-1 address, one per core |
| loc_wdata | input | 2x32 | Port-1 write data, one per core |
| loc_rdata | output | 2x32 | Port-1 read data, one cycle after the read |
| share_wr | input | 2 | Load strobe for the sharing bit, one per core |
| share_val | input | 2 | Value to load into the sharing bit (1 = accept neighbour writes) |
| strm_lut_mode | input | 2 | Streamer is in a lookup-RAM mode, one per core |
| strm_rd | input | 2 | Streamer read request, one per core |
| strm_addr | input | 2x9 | Streamer read address, one per core |
| strm_rdata | output | 2x32 | Port-2 data delivered to the streamer |
| strm_valid | output | 2 | A lookup-mode streamer read completed last cycle |
| strm_conflict | output | 2 | That streamer read was overridden by a neighbour write |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. That covers port-1 read data, streamer data with its valid and conflict flags, and a changed sharing bit starting to govern neighbour writes. The bench applies stimulus just after a falling edge, lets one rising edge pass, and samples on the next falling edge. Whether a neighbour write landed is judged by reading the partner's RAM through its own port 1 afterwards. The same-cycle cases are each set up in a single cycle: a share update arriving together with a write, a clash on port 2, and two writes to one address.

// File: rtl/lut_share_pkg.sv
package lut_share_pkg;
  // who holds the second RAM port in a given cycle
  typedef enum logic [1:0] {
    P2_IDLE   = 2'd0,
    P2_STREAM = 2'd1,
    P2_REMOTE = 2'd2
  } p2_owner_e;
endpackage

// File: rtl/lut_dpram.sv
module lut_dpram #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  // port A: owning core, read-first
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  // port B: streamer read or remote write, write-first
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // port A is written last so that it wins an address collision
  always_ff @(posedge clk) begin
    if (b_en && b_we) mem[b_addr] <= b_wdata;
    if (a_en && a_we) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                a_rdata <= '0;
    else if (a_en && !a_we) a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)               b_rdata <= '0;
    else if (b_en && b_we) b_rdata <= b_wdata;
    else if (b_en)         b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/lut_port2_arb.sv
module lut_port2_arb
  import lut_share_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          share_on,
  input  logic          rem_we,
  input  logic [AW-1:0] rem_addr,
  input  logic [DW-1:0] rem_wdata,
  input  logic          lut_mode,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output p2_owner_e     owner,
  output logic          p2_we,
  output logic [AW-1:0] p2_addr,
  output logic [DW-1:0] p2_wdata,
  output logic          clash
);
  logic rem_ok;
  logic strm_ok;

  always_comb begin
    rem_ok   = rem_we && share_on;
    strm_ok  = lut_mode && rd_req;
    clash    = rem_ok && strm_ok;
    owner    = P2_IDLE;
    p2_we    = 1'b0;
    p2_addr  = rd_addr;
    p2_wdata = rem_wdata;
    if (rem_ok) begin
      owner   = P2_REMOTE;
      p2_we   = 1'b1;
      p2_addr = rem_addr;
    end else if (strm_ok) begin
      owner = P2_STREAM;
    end
  end
endmodule

// File: rtl/lut_core_slice.sv
module lut_core_slice
  import lut_share_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loc_en,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata,
  input  logic          share_wr,
  input  logic          share_val,
  input  logic          rem_we,
  input  logic [AW-1:0] rem_addr,
  input  logic [DW-1:0] rem_wdata,
  input  logic          lut_mode,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] strm_rdata,
  output logic          strm_valid,
  output logic          strm_conflict
);
  logic          share_q;
  p2_owner_e     owner;
  logic          p2_en;
  logic          p2_we;
  logic [AW-1:0] p2_addr;
  logic [DW-1:0] p2_wdata;
  logic          clash;

  always_ff @(posedge clk) begin
    if (rst)           share_q <= 1'b0;
    else if (share_wr) share_q <= share_val;
  end

  lut_port2_arb #(.AW(AW), .DW(DW)) u_arb (
    .share_on (share_q),
    .rem_we   (rem_we),
    .rem_addr (rem_addr),
    .rem_wdata(rem_wdata),
    .lut_mode (lut_mode),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .owner    (owner),
    .p2_we    (p2_we),
    .p2_addr  (p2_addr),
    .p2_wdata (p2_wdata),
    .clash    (clash)
  );

  assign p2_en = (owner != P2_IDLE);

  lut_dpram #(.AW(AW), .DW(DW)) u_ram (
    .clk    (clk),
    .rst    (rst),
    .a_en   (loc_en),
    .a_we   (loc_we),
    .a_addr (loc_addr),
    .a_wdata(loc_wdata),
    .a_rdata(loc_rdata),
    .b_en   (p2_en),
    .b_we   (p2_we),
    .b_addr (p2_addr),
    .b_wdata(p2_wdata),
    .b_rdata(strm_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      strm_valid    <= 1'b0;
      strm_conflict <= 1'b0;
    end else begin
      strm_valid    <= lut_mode && rd_req;
      strm_conflict <= clash;
    end
  end

  // R4: a closed share bit keeps port 2 from writing
  p_closed_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    !share_q |-> !p2_we);
  // R6: a lookup-mode read yields a valid result one cycle later
  p_stream_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (lut_mode && rd_req) |=> strm_valid);
  // R7: an overridden read returns the remote write data
  p_conflict_data_r7: assert property (@(posedge clk) disable iff (rst)
    (rem_we && share_q && lut_mode && rd_req) |=> (strm_conflict && strm_rdata == $past(rem_wdata)));
  // R8: non-lookup modes leave port 2 to the remote writer alone
  p_nonlut_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !lut_mode |=> (!strm_valid && !strm_conflict));
  // R10: conflict only accompanies a completed read
  p_conflict_valid_r10: assert property (@(posedge clk) disable iff (rst)
    strm_conflict |-> strm_valid);
endmodule

// File: rtl/lut_share_pair.sv
module lut_share_pair #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          loc_en,
  input  logic [1:0]          loc_we,
  input  logic [1:0][AW-1:0]  loc_addr,
  input  logic [1:0][DW-1:0]  loc_wdata,
  output logic [1:0][DW-1:0]  loc_rdata,
  input  logic [1:0]          share_wr,
  input  logic [1:0]          share_val,
  input  logic [1:0]          strm_lut_mode,
  input  logic [1:0]          strm_rd,
  input  logic [1:0][AW-1:0]  strm_addr,
  output logic [1:0][DW-1:0]  strm_rdata,
  output logic [1:0]          strm_valid,
  output logic [1:0]          strm_conflict
);
  localparam int NCORE = 2;

  logic [NCORE-1:0] loc_wr;
  assign loc_wr = loc_en & loc_we;

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    localparam int PEER = i ^ 1;
    lut_core_slice #(.AW(AW), .DW(DW)) u_slice (
      .clk          (clk),
      .rst          (rst),
      .loc_en       (loc_en[i]),
      .loc_we       (loc_we[i]),
      .loc_addr     (loc_addr[i]),
      .loc_wdata    (loc_wdata[i]),
      .loc_rdata    (loc_rdata[i]),
      .share_wr     (share_wr[i]),
      .share_val    (share_val[i]),
      .rem_we       (loc_wr[PEER]),
      .rem_addr     (loc_addr[PEER]),
      .rem_wdata    (loc_wdata[PEER]),
      .lut_mode     (strm_lut_mode[i]),
      .rd_req       (strm_rd[i]),
      .rd_addr      (strm_addr[i]),
      .strm_rdata   (strm_rdata[i]),
      .strm_valid   (strm_valid[i]),
      .strm_conflict(strm_conflict[i])
    );
  end
endmodule

// File: tb/lut_share_pair_bench.sv
module lut_share_pair_bench;
  localparam int AW = 9;
  localparam int DW = 32;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [1:0]          loc_en = '0, loc_we = '0;
  logic [1:0][AW-1:0]  loc_addr = '0;
  logic [1:0][DW-1:0]  loc_wdata = '0;
  logic [1:0][DW-1:0]  loc_rdata;
  logic [1:0]          share_wr = '0, share_val = '0;
  logic [1:0]          strm_lut_mode = '0, strm_rd = '0;
  logic [1:0][AW-1:0]  strm_addr = '0;
  logic [1:0][DW-1:0]  strm_rdata;
  logic [1:0]          strm_valid, strm_conflict;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lut_share_pair #(.AW(AW), .DW(DW)) u_lut_share_pair (.*);

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic lwrite(int c, logic [AW-1:0] a, logic [DW-1:0] d);
    loc_en[c] = 1'b1; loc_we[c] = 1'b1; loc_addr[c] = a; loc_wdata[c] = d;
    cycle();
    loc_en[c] = 1'b0; loc_we[c] = 1'b0;
  endtask

  task automatic lread(int c, logic [AW-1:0] a, output logic [DW-1:0] d);
    loc_en[c] = 1'b1; loc_we[c] = 1'b0; loc_addr[c] = a;
    cycle();
    d = loc_rdata[c];
    loc_en[c] = 1'b0;
  endtask

  task automatic setshare(int c, logic v);
    share_wr[c] = 1'b1; share_val[c] = v;
    cycle();
    share_wr[c] = 1'b0;
  endtask

  task automatic t_reset();
    for (int c = 0; c < 2; c++) begin
      check("R1 loc_rdata", loc_rdata[c], '0);
      check("R1 strm_valid", {31'd0, strm_valid[c]}, 32'd0);
      check("R1 strm_conflict", {31'd0, strm_conflict[c]}, 32'd0);
    end
  endtask

  task automatic t_local();
    logic [DW-1:0] d;
    lwrite(0, 9'd5, 32'hA5A5_0001);
    lread(0, 9'd5, d);
    check("R2 port1 readback", d, 32'hA5A5_0001);
  endtask

  task automatic t_closed();
    logic [DW-1:0] d;
    lwrite(1, 9'd10, 32'hC0C0_0010);
    lwrite(0, 9'd10, 32'hB0B0_0010);
    lread(1, 9'd10, d);
    check("R4 rejected neighbour write", d, 32'hC0C0_0010);
    check("R1 share bit resets closed", d, 32'hC0C0_0010);
  endtask

  task automatic t_open();
    logic [DW-1:0] d;
    setshare(1, 1'b1);
    lwrite(0, 9'd10, 32'hD0D0_0010);
    lread(1, 9'd10, d);
    check("R3 mirrored write", d, 32'hD0D0_0010);
    lread(0, 9'd10, d);
    check("R3 own copy", d, 32'hD0D0_0010);
  endtask

  task automatic t_stream();
    strm_lut_mode[1] = 1'b1; strm_rd[1] = 1'b1; strm_addr[1] = 9'd10;
    cycle();
    strm_rd[1] = 1'b0;
    check("R6 stream data", strm_rdata[1], 32'hD0D0_0010);
    check("R6 stream valid", {31'd0, strm_valid[1]}, 32'd1);
    check("R10 no conflict alone", {31'd0, strm_conflict[1]}, 32'd0);
  endtask

  task automatic t_share_edge();
    logic [DW-1:0] d;
    lwrite(1, 9'd51, 32'h5151_0000);
    share_wr[1] = 1'b1; share_val[1] = 1'b0;
    loc_en[0] = 1'b1; loc_we[0] = 1'b1; loc_addr[0] = 9'd50; loc_wdata[0] = 32'h5050_ABCD;
    cycle();
    share_wr[1] = 1'b0; loc_en[0] = 1'b0; loc_we[0] = 1'b0;
    lwrite(0, 9'd51, 32'hBAD0_0051);
    lread(1, 9'd50, d);
    check("R5 old share value applies", d, 32'h5050_ABCD);
    lread(1, 9'd51, d);
    check("R5 new share value applies", d, 32'h5151_0000);
  endtask

  task automatic t_clash();
    logic [DW-1:0] d;
    setshare(1, 1'b1);
    lwrite(1, 9'd20, 32'hEEEE_0020);
    strm_lut_mode[1] = 1'b1; strm_rd[1] = 1'b1; strm_addr[1] = 9'd20;
    loc_en[0] = 1'b1; loc_we[0] = 1'b1; loc_addr[0] = 9'd30; loc_wdata[0] = 32'hF00F_0030;
    cycle();
    strm_rd[1] = 1'b0; loc_en[0] = 1'b0; loc_we[0] = 1'b0;
    check("R7 clash data", strm_rdata[1], 32'hF00F_0030);
    check("R7 clash flag", {31'd0, strm_conflict[1]}, 32'd1);
    check("R7 clash valid", {31'd0, strm_valid[1]}, 32'd1);
    lread(1, 9'd30, d);
    check("R7 write landed", d, 32'hF00F_0030);
    lread(1, 9'd20, d);
    check("R7 target untouched", d, 32'hEEEE_0020);
  endtask

  task automatic t_nonlut();
    logic [DW-1:0] d;
    strm_lut_mode[1] = 1'b0; strm_rd[1] = 1'b1; strm_addr[1] = 9'd20;
    loc_en[0] = 1'b1; loc_we[0] = 1'b1; loc_addr[0] = 9'd31; loc_wdata[0] = 32'h3131_0031;
    cycle();
    strm_rd[1] = 1'b0; loc_en[0] = 1'b0; loc_we[0] = 1'b0;
    check("R8 no valid", {31'd0, strm_valid[1]}, 32'd0);
    check("R8 no conflict", {31'd0, strm_conflict[1]}, 32'd0);
    lread(1, 9'd31, d);
    check("R8 write still lands", d, 32'h3131_0031);
  endtask

  task automatic t_same_addr();
    logic [DW-1:0] d;
    loc_en = 2'b11; loc_we = 2'b11;
    loc_addr[0] = 9'd40; loc_wdata[0] = 32'h4040_000A;
    loc_addr[1] = 9'd40; loc_wdata[1] = 32'h4040_000B;
    cycle();
    loc_en = 2'b00; loc_we = 2'b00;
    lread(1, 9'd40, d);
    check("R9 own write wins", d, 32'h4040_000B);
    lread(0, 9'd40, d);
    check("R9 closed partner keeps own", d, 32'h4040_000A);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_local();
    t_closed();
    t_open();
    t_stream();
    t_share_edge();
    t_clash();
    t_nonlut();
    t_same_addr();
    repeat (2) cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule